// File: doc/BRIEF.md
# Sixteen-Pin I/O Port with Per-Pin Interrupts

This block is one port of general-purpose I/O, instanced once per group of sixteen pins. It drives an output value and an output-enable vector toward the pads, and samples the pad inputs through a two-stage synchronizer. Software reaches it through a small register bus with a valid, a write strobe, an address and write data. Read data is registered and appears on `bus_rdata` in the cycle after the read request.

Four per-pin configuration vectors control the port: output enable, interrupt enable, trigger type and trigger polarity. Software never writes these vectors directly. Each vector has a set address and a clear address. A one written to a set address sets bits in the vector, and a one written to a clear address removes them. Reading either address returns the current vector.

Each pin watches its synchronized input for one of four conditions, chosen by the pair {type, polarity}. When the condition holds and the pin's interrupt is enabled, the pin latches a sticky status bit. Writing one to that status bit clears it. All status bits are combined into one registered interrupt line.

Top module: `pinport_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are all zero, and `irq` is low.
- R2: Bits 31:16 of every read are zero, and write-data bits 31:16 are ignored.
- R3: The configuration vectors sit at these set/clear offsets: output enable 0x10/0x14, interrupt enable 0x20/0x24, type 0x28/0x2C, polarity 0x30/0x34. A one in a write to a set offset sets that bit, and a one in a write to a clear offset clears it. Zero bits leave the vector unchanged. Both offsets read back the vector. The output-enable vector drives `pad_oe`.
- R4: A write to 0x00 or 0x04 loads the output value onto `pad_out`, and 0x04 reads that value back. A read of 0x00 returns the pad inputs after two synchronizer flops, so a pad change becomes visible to a read captured at the third rising edge after the change.
- R5: With type 0 and polarity 0, a pin whose synchronized input is low sets its status bit.
- R6: With type 0 and polarity 1, a pin whose synchronized input is high sets its status bit.
- R7: With type 1 and polarity 0, a falling edge between two consecutive synchronized samples sets the status bit.
- R8: With type 1 and polarity 1, a rising edge between two consecutive synchronized samples sets the status bit.
- R9: The status register is at 0x38. A one written to a status bit clears it in that cycle, and a zero has no effect. If a level trigger still holds, the bit sets again one cycle after the clear. An edge trigger stays cleared.
- R10: A trigger condition sets a status bit only while that pin's interrupt enable is set. An edge that happens while the interrupt is disabled is not remembered.
- R11: `irq` is a registered OR of all status bits. It goes high one cycle after a status bit sets and goes low one cycle after the last status bit clears.
- R12: Reads of unmapped offsets return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Output value to the pads |
| pad_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest behaviour to reach from the ports is a level trigger re-asserting in the cycle right after a status clear. Clearing a status bit and reading it back are both bus operations, so the window is one cycle wide. The bench writes the clear and issues a status read on the very next cycle, which must return zero. A read on the following cycle must then return the bit set again. Edge timing is harder still, because the pad has to pass two synchronizer flops, the edge detector and the status flop before `irq` moves. The bench therefore samples `irq` at exact cycle counts after the pad change.

// File: rtl/pinport_pkg.sv
package pinport_pkg;
    // Register byte offsets
    localparam int OFS_DATA     = 'h00;
    localparam int OFS_DOUT     = 'h04;
    localparam int OFS_OE_SET   = 'h10;
    localparam int OFS_OE_CLR   = 'h14;
    localparam int OFS_IE_SET   = 'h20;
    localparam int OFS_IE_CLR   = 'h24;
    localparam int OFS_TYP_SET  = 'h28;
    localparam int OFS_TYP_CLR  = 'h2C;
    localparam int OFS_POL_SET  = 'h30;
    localparam int OFS_POL_CLR  = 'h34;
    localparam int OFS_STAT     = 'h38;

    // Trigger mode formed as {type, polarity}
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_mode_e;
endpackage

// File: rtl/pinport_sync.sv
module pinport_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= raw;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/pinport_detect.sv
module pinport_detect
    import pinport_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] kind,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        trig_mode_e mode;
        assign mode = trig_mode_e'({kind[g], pol[g]});

        always_comb begin
            unique case (mode)
                TRIG_LOW:  hit[g] = ~cur[g];
                TRIG_HIGH: hit[g] =  cur[g];
                TRIG_FALL: hit[g] = ~cur[g] &  prev[g];
                TRIG_RISE: hit[g] =  cur[g] & ~prev[g];
                default:   hit[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pinport_regs.sv
module pinport_regs
    import pinport_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  wbits,
    output logic [DW-1:0] bus_rdata,
    input  logic [W-1:0]  pin_val,
    input  logic [W-1:0]  hit,
    output logic [W-1:0]  dout,
    output logic [W-1:0]  oe_vec,
    output logic [W-1:0]  ie_vec,
    output logic [W-1:0]  kind_vec,
    output logic [W-1:0]  pol_vec,
    output logic [W-1:0]  stat_vec
);
    localparam int NCFG = 4;
    localparam logic [AW-1:0] SET_OFS [NCFG] = '{AW'(OFS_OE_SET), AW'(OFS_IE_SET),
                                                 AW'(OFS_TYP_SET), AW'(OFS_POL_SET)};
    localparam logic [AW-1:0] CLR_OFS [NCFG] = '{AW'(OFS_OE_CLR), AW'(OFS_IE_CLR),
                                                 AW'(OFS_TYP_CLR), AW'(OFS_POL_CLR)};
    localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
    localparam logic [AW-1:0] A_DOUT = AW'(OFS_DOUT);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);

    logic         wr, rd;
    logic [W-1:0] cfg [NCFG];
    logic [W-1:0] clr_mask;
    logic [W-1:0] rmux;

    assign wr = bus_valid &  bus_write;
    assign rd = bus_valid & ~bus_write;

    // Set/clear configuration vectors
    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        logic [W-1:0] set_m, clr_m;
        assign set_m = (wr && bus_addr == SET_OFS[k]) ? wbits : '0;
        assign clr_m = (wr && bus_addr == CLR_OFS[k]) ? wbits : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg[k] <= '0;
            else        cfg[k] <= (cfg[k] | set_m) & ~clr_m;
        end
    end

    assign oe_vec   = cfg[0];
    assign ie_vec   = cfg[1];
    assign kind_vec = cfg[2];
    assign pol_vec  = cfg[3];

    // Output value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout <= '0;
        else if (wr && (bus_addr == A_DATA || bus_addr == A_DOUT))
            dout <= wbits;
    end

    // Sticky status, clear wins in its own cycle
    assign clr_mask = (wr && bus_addr == A_STAT) ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_vec <= '0;
        else        stat_vec <= (stat_vec | (hit & ie_vec)) & ~clr_mask;
    end

    // Read mux
    always_comb begin
        rmux = '0;
        if (bus_addr == A_DATA) rmux = pin_val;
        if (bus_addr == A_DOUT) rmux = dout;
        if (bus_addr == A_STAT) rmux = stat_vec;
        for (int k = 0; k < NCFG; k++) begin
            if (bus_addr == SET_OFS[k] || bus_addr == CLR_OFS[k]) rmux = cfg[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= DW'(rmux);
        else         bus_rdata <= '0;
    end
endmodule

// File: rtl/pinport_ctrl.sv
module pinport_ctrl #(
    parameter int PIN_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic              irq
);
    logic [PIN_W-1:0] pin_cur, pin_prev, hit;
    logic [PIN_W-1:0] oe_vec, ie_vec, kind_vec, pol_vec, stat_vec, dout;

    pinport_sync #(.W(PIN_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pad_in),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    pinport_detect #(.W(PIN_W)) u_detect (
        .cur (pin_cur),
        .prev(pin_prev),
        .kind(kind_vec),
        .pol (pol_vec),
        .hit (hit)
    );

    pinport_regs #(.W(PIN_W), .AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .wbits    (bus_wdata[PIN_W-1:0]),
        .bus_rdata(bus_rdata),
        .pin_val  (pin_cur),
        .hit      (hit),
        .dout     (dout),
        .oe_vec   (oe_vec),
        .ie_vec   (ie_vec),
        .kind_vec (kind_vec),
        .pol_vec  (pol_vec),
        .stat_vec (stat_vec)
    );

    assign pad_out = dout;
    assign pad_oe  = oe_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |stat_vec;
    end
endmodule

// File: rtl/pinport_checker.sv
module pinport_checker
    import pinport_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [W-1:0]  pad_oe,
    input logic          irq,
    input logic [W-1:0]  stat_vec,
    input logic [W-1:0]  ie_vec
);
    p_rdata_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata >> W) == '0);

    p_oe_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == AW'(OFS_OE_CLR))
        |=> ((pad_oe & $past(bus_wdata[W-1:0])) == '0));

    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == AW'(OFS_STAT))
        |=> ((stat_vec & $past(bus_wdata[W-1:0])) == '0));

    p_stat_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec & ~$past(stat_vec) & ~$past(ie_vec)) == '0);

    p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_vec) |=> irq);

    p_irq_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|stat_vec) |=> !irq);
endmodule

bind pinport_ctrl pinport_checker #(.W(PIN_W), .AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_oe   (pad_oe),
    .irq      (irq),
    .stat_vec (stat_vec),
    .ie_vec   (ie_vec)
);

// File: tb/pinport_ctrl_bench.sv
module pinport_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic        irq;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    pinport_ctrl u_pinport_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // {op(1=write), addr, wdata, expected read}
    localparam int NV = 26;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h10, 32'hFFFF00A5, 32'h0},       // R2 R3 upper bits ignored
        {1'b0, 8'h10, 32'h0, 32'h000000A5},       // R3
        {1'b0, 8'h14, 32'h0, 32'h000000A5},       // R3 clear offset reads vector
        {1'b1, 8'h14, 32'h00000005, 32'h0},       // R3
        {1'b0, 8'h10, 32'h0, 32'h000000A0},       // R3
        {1'b1, 8'h10, 32'h00000000, 32'h0},       // R3 zero has no effect
        {1'b0, 8'h14, 32'h0, 32'h000000A0},       // R3
        {1'b1, 8'h04, 32'h00001234, 32'h0},       // R4
        {1'b0, 8'h04, 32'h0, 32'h00001234},       // R4
        {1'b1, 8'h00, 32'h0000BEEF, 32'h0},       // R4 write to data offset
        {1'b0, 8'h04, 32'h0, 32'h0000BEEF},       // R4
        {1'b1, 8'h3C, 32'h0000FFFF, 32'h0},       // R12
        {1'b0, 8'h3C, 32'h0, 32'h00000000},       // R12
        {1'b0, 8'h08, 32'h0, 32'h00000000},       // R12
        {1'b1, 8'h28, 32'h00000F0F, 32'h0},       // R3 type
        {1'b0, 8'h2C, 32'h0, 32'h00000F0F},       // R3
        {1'b1, 8'h2C, 32'h00000003, 32'h0},       // R3
        {1'b0, 8'h28, 32'h0, 32'h00000F0C},       // R3
        {1'b1, 8'h30, 32'h000000F0, 32'h0},       // R3 polarity
        {1'b0, 8'h34, 32'h0, 32'h000000F0},       // R3
        {1'b1, 8'h34, 32'h000000F0, 32'h0},       // R3
        {1'b0, 8'h30, 32'h0, 32'h00000000},       // R3
        {1'b1, 8'h2C, 32'h0000FFFF, 32'h0},       // R3
        {1'b0, 8'h28, 32'h0, 32'h00000000},       // R3
        {1'b1, 8'h14, 32'h0000FFFF, 32'h0},       // R3
        {1'b0, 8'h10, 32'h0, 32'h00000000}        // R3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
        check("R1 pad_out", {16'h0, pad_out}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(8'h38, r); check("R1 status", r, 32'h0);
        rd(8'h20, r); check("R1 int enable", r, 32'h0);
        rd(8'h28, r); check("R1 type", r, 32'h0);

        // Table walk: R2 R3 R4 R12
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], r);
                check($sformatf("table step %0d (R2/R3/R4/R12)", i), r, VEC[i][31:0]);
            end
        end
        check("R4 pad_out after table", {16'h0, pad_out}, 32'h0000BEEF);
        check("R3 pad_oe after clear", {16'h0, pad_oe}, 32'h0);
        wr(8'h10, 32'h000000FF);
        check("R3 pad_oe set", {16'h0, pad_oe}, 32'h000000FF);
        wr(8'h14, 32'h000000FF);

        // R4 synchronizer latency
        pad_in = 16'h5A3C;
        rd(8'h00, r); check("R4 pad read before sync", r, 32'h0);
        idle(1);
        rd(8'h00, r); check("R4 pad read after sync", r, 32'h00005A3C);

        // R5 low level on pin 3
        pad_in = 16'hFFFF;
        idle(4);
        wr(8'h20, 32'h00000008);
        idle(4);
        rd(8'h38, r); check("R5 no trigger while high", r, 32'h0);
        pad_in[3] = 1'b0;
        idle(5);
        rd(8'h38, r); check("R5 low level status", r, 32'h00000008);
        check("R11 irq with status", {31'h0, irq}, 32'h1);
        pad_in[3] = 1'b1;
        idle(4);
        wr(8'h38, 32'h00000008);
        wr(8'h24, 32'h00000008);
        rd(8'h38, r); check("R5 cleared", r, 32'h0);

        // R6 high level on pin 5, R9 re-assert
        pad_in[5] = 1'b0;
        wr(8'h30, 32'h00000020);
        idle(4);
        wr(8'h20, 32'h00000020);
        idle(4);
        rd(8'h38, r); check("R6 no trigger while low", r, 32'h0);
        pad_in[5] = 1'b1;
        idle(5);
        rd(8'h38, r); check("R6 high level status", r, 32'h00000020);
        wr(8'h38, 32'h00000020);
        rd(8'h38, r); check("R9 cleared in clear cycle", r, 32'h0);
        rd(8'h38, r); check("R9 level re-asserts next cycle", r, 32'h00000020);
        wr(8'h38, 32'h00000000);
        rd(8'h38, r); check("R9 zero write keeps status", r, 32'h00000020);
        pad_in[5] = 1'b0;
        idle(4);
        wr(8'h38, 32'h00000020);
        idle(2);
        rd(8'h38, r); check("R9 stays clear once level gone", r, 32'h0);
        check("R11 irq drops", {31'h0, irq}, 32'h0);
        wr(8'h24, 32'h00000020);
        wr(8'h34, 32'h00000020);

        // R7 falling edge on pin 7
        wr(8'h28, 32'h00000080);
        idle(4);
        wr(8'h20, 32'h00000080);
        idle(3);
        rd(8'h38, r); check("R7 no trigger while steady high", r, 32'h0);
        pad_in[7] = 1'b0;
        idle(5);
        rd(8'h38, r); check("R7 falling edge status", r, 32'h00000080);
        wr(8'h38, 32'h00000080);
        idle(3);
        rd(8'h38, r); check("R9 edge does not re-assert", r, 32'h0);
        wr(8'h24, 32'h00000080);
        wr(8'h2C, 32'h00000080);

        // R8 rising edge on pin 9 with R11 irq timing
        pad_in[9] = 1'b0;
        wr(8'h28, 32'h00000200);
        wr(8'h30, 32'h00000200);
        idle(4);
        wr(8'h20, 32'h00000200);
        idle(3);
        check("R11 irq idle before edge", {31'h0, irq}, 32'h0);
        pad_in[9] = 1'b1;
        idle(3);
        check("R11 irq low in status-set cycle", {31'h0, irq}, 32'h0);
        idle(1);
        check("R11 irq one cycle later", {31'h0, irq}, 32'h1);
        rd(8'h38, r); check("R8 rising edge status", r, 32'h00000200);
        wr(8'h38, 32'h00000200);
        wr(8'h24, 32'h00000200);
        idle(2);
        check("R11 irq low after clear", {31'h0, irq}, 32'h0);

        // R10 edge while disabled is not remembered (pin 11)
        pad_in[11] = 1'b0;
        wr(8'h28, 32'h00000800);
        wr(8'h30, 32'h00000800);
        idle(4);
        pad_in[11] = 1'b1;
        idle(5);
        rd(8'h38, r); check("R10 disabled pin no status", r, 32'h0);
        wr(8'h20, 32'h00000800);
        idle(4);
        rd(8'h38, r); check("R10 enabling later sets nothing", r, 32'h0);
        check("R10 irq stays low", {31'h0, irq}, 32'h0);

        finish_run();
    end
endmodule